// File: doc/BRIEF.md
# Walsh-Hadamard Bit-Stream Spectrum Analyzer

This block measures how much structure a fixed-length binary sequence carries. An example is the run of values one circuit input takes across a whole test set. The bits arrive serially after a start pulse. Each bit is turned into a signed unit value, and the block correlates the whole sequence with every Walsh function. It does this with an in-place fast Walsh-Hadamard transform, one butterfly stage per clock cycle.

When the transform is finished, the block streams out all coefficients in index order, one per cycle. Each coefficient carries a flag that marks it as essential or as noise. A coefficient is essential when its normalized power, c²/N², is above the level expected from a purely random sequence, which is 1/N. A host that perturbs noise components while keeping the essential ones can use this flag directly. A one-cycle done pulse closes each spectrum.

Top module: `walsh_spectrum_analyzer`

## Requirements
- R1: After a start pulse is accepted, the next N_PTS cycles with `bit_valid_i` high capture sample 0 up to sample N_PTS-1, in arrival order. Cycles with `bit_valid_i` low are skipped. A captured bit 1 counts as +1 and a bit 0 counts as -1.
- R2: Coefficient k equals the sum over n of x[n]·(-1)^popcount(k AND n). This is the Sylvester-ordered Hadamard matrix: row 1 alternates +1/-1, row 2 alternates in pairs, and row N_PTS/2 is +1 over the first half and -1 over the second half.
- R3: Coefficients are two's-complement values of log2(N_PTS)+2 bits, always inside [-N_PTS, +N_PTS] and always even.
- R4: `coef_ess_o` is 1 exactly when c² > N_PTS. For N_PTS = 128, |c| ≥ 12 is essential, and |c| ≤ 10 is noise, which includes 0.
- R5: After the cycle that captures the last sample, log2(N_PTS) transform cycles follow. Then `coef_valid_o` stays high for N_PTS consecutive cycles, with `coef_idx_o` counting 0 up to N_PTS-1. The first coefficient is therefore present log2(N_PTS)+1 cycles after the last-sample edge.
- R6: `done_o` is high for exactly one cycle, right after the cycle that carries index N_PTS-1. After that the block accepts a new start.
- R7: `start_i` has no effect while the block is capturing, transforming, emitting or signalling done. `bit_valid_i` has no effect outside the capture phase.
- R8: Driving `rst_n` low at once clears all sample storage and the control state, so `coef_valid_o`, `done_o` and `coef_val_o` read 0. Release of the reset takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin capturing a new stream (acted on only when idle) |
| bit_valid_i | input | 1 | `bit_i` carries a sample this cycle |
| bit_i | input | 1 | Serial sample bit |
| coef_valid_o | output | 1 | A coefficient is present on the outputs |
| coef_idx_o | output | log2(N_PTS) | Walsh index of the present coefficient |
| coef_val_o | output | log2(N_PTS)+2 | Signed coefficient value |
| coef_ess_o | output | 1 | Coefficient is essential (1) or noise (0) |
| done_o | output | 1 | One-cycle pulse after the last coefficient |

## Verification
Every coefficient depends on all stored samples, so a single corrupted storage word or a misrouted butterfly spoils many coefficients, not just one. The corruption shows up as wrong values on the very first emitted spectrum, from index 0 onward. A stray restart or a miscounted phase moves the first `coef_valid_o` away from its fixed latency, or moves `done_o`, and this is visible within one stream length. Parity and range errors in the adders appear as odd or out-of-range values on the cycle they are emitted.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_LOAD  = 3'd1,
    WS_XFORM = 3'd2,
    WS_EMIT  = 3'd3,
    WS_DONE  = 3'd4
  } wsa_state_e;

endpackage

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
  import wsa_pkg::*;
#(
  parameter int N_PTS = 128,
  localparam int IDX_W = $clog2(N_PTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_valid_i,
  output logic             load_en_o,
  output logic             xform_en_o,
  output logic             emit_en_o,
  output logic             done_o,
  output logic [IDX_W-1:0] cnt_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PTS - 1);
  localparam logic [IDX_W-1:0] LAST_STG = IDX_W'(IDX_W - 1);

  wsa_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             adv_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      WS_IDLE: begin
        if (start_i) begin
          st_d  = WS_LOAD;
          cnt_d = '0;
        end
      end
      WS_LOAD: begin
        if (bit_valid_i) begin
          if (cnt_q == LAST_IDX) begin
            st_d  = WS_XFORM;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      WS_XFORM: begin
        if (cnt_q == LAST_STG) begin
          st_d  = WS_EMIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WS_EMIT: begin
        if (cnt_q == LAST_IDX) begin
          st_d  = WS_DONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WS_DONE: st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  assign adv_en = (st_q != WS_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      cnt_q <= '0;
    end else if (adv_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign load_en_o  = (st_q == WS_LOAD) && bit_valid_i;
  assign xform_en_o = (st_q == WS_XFORM);
  assign emit_en_o  = (st_q == WS_EMIT);
  assign done_o     = (st_q == WS_DONE);
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/wsa_butterfly_net.sv
module wsa_butterfly_net #(
  parameter int N_PTS = 128,
  parameter int CW    = 9
) (
  input  logic signed [CW-1:0] x_i [N_PTS],
  output logic signed [CW-1:0] y_o [N_PTS]
);

  localparam int HALF = N_PTS / 2;

  // Constant-geometry stage: pair (2i, 2i+1) feeds sum to i, difference to i+HALF.
  for (genvar i = 0; i < HALF; i++) begin : g_bfly
    assign y_o[i]        = x_i[2*i] + x_i[2*i+1];
    assign y_o[i + HALF] = x_i[2*i] - x_i[2*i+1];
  end

endmodule

// File: rtl/wsa_sample_store.sv
module wsa_sample_store #(
  parameter int N_PTS = 128,
  parameter int CW    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en_i,
  input  logic signed [CW-1:0] load_val_i,
  input  logic                 xform_en_i,
  input  logic signed [CW-1:0] xform_val_i [N_PTS],
  input  logic                 emit_en_i,
  output logic signed [CW-1:0] smp_o [N_PTS]
);

  logic signed [CW-1:0] smp_q [N_PTS];
  logic signed [CW-1:0] smp_d [N_PTS];
  logic                 wr_en;

  always_comb begin
    smp_d = smp_q;
    if (xform_en_i) begin
      smp_d = xform_val_i;
    end else if (load_en_i || emit_en_i) begin
      for (int k = 0; k < N_PTS - 1; k++) begin
        smp_d[k] = smp_q[k+1];
      end
      smp_d[N_PTS-1] = load_en_i ? load_val_i : '0;
    end
  end

  assign wr_en = load_en_i || xform_en_i || emit_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_PTS; k++) begin
        smp_q[k] <= '0;
      end
    end else if (wr_en) begin
      smp_q <= smp_d;
    end
  end

  assign smp_o = smp_q;

endmodule

// File: rtl/wsa_classifier.sv
module wsa_classifier #(
  parameter int N_PTS = 128,
  parameter int CW    = 9
) (
  input  logic signed [CW-1:0] coef_i,
  output logic                 ess_o
);

  localparam int SQ_W = 2 * CW;
  localparam logic [SQ_W-1:0] THR = SQ_W'(N_PTS);

  logic signed [SQ_W-1:0] sq;

  // Power c^2/N^2 against 1/N reduces to c^2 against N.
  assign sq    = coef_i * coef_i;
  assign ess_o = $unsigned(sq) > THR;

endmodule

// File: rtl/walsh_spectrum_analyzer.sv
module walsh_spectrum_analyzer #(
  parameter int N_PTS = 128,
  localparam int IDX_W = $clog2(N_PTS),
  localparam int CW = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 bit_valid_i,
  input  logic                 bit_i,
  output logic                 coef_valid_o,
  output logic [IDX_W-1:0]     coef_idx_o,
  output logic signed [CW-1:0] coef_val_o,
  output logic                 coef_ess_o,
  output logic                 done_o
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic                 load_en, xform_en, emit_en;
  logic [IDX_W-1:0]     cnt;
  logic signed [CW-1:0] load_val;
  logic signed [CW-1:0] smp [N_PTS];
  logic signed [CW-1:0] stage_out [N_PTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  assign load_val = bit_i ? CW'(1) : {CW{1'b1}};

  wsa_ctrl #(.N_PTS(N_PTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .bit_valid_i(bit_valid_i),
    .load_en_o  (load_en),
    .xform_en_o (xform_en),
    .emit_en_o  (emit_en),
    .done_o     (done_o),
    .cnt_o      (cnt)
  );

  wsa_butterfly_net #(.N_PTS(N_PTS), .CW(CW)) u_net (
    .x_i(smp),
    .y_o(stage_out)
  );

  wsa_sample_store #(.N_PTS(N_PTS), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_en_i  (load_en),
    .load_val_i (load_val),
    .xform_en_i (xform_en),
    .xform_val_i(stage_out),
    .emit_en_i  (emit_en),
    .smp_o      (smp)
  );

  wsa_classifier #(.N_PTS(N_PTS), .CW(CW)) u_cls (
    .coef_i(smp[0]),
    .ess_o (coef_ess_o)
  );

  assign coef_valid_o = emit_en;
  assign coef_idx_o   = cnt;
  assign coef_val_o   = smp[0];

endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int N_PTS = 128,
  localparam int IDX_W = $clog2(N_PTS),
  localparam int CW = IDX_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 coef_valid_o,
  input logic [IDX_W-1:0]     coef_idx_o,
  input logic signed [CW-1:0] coef_val_o,
  input logic                 coef_ess_o,
  input logic                 done_o
);

  localparam logic signed [CW-1:0] CMAX = CW'(N_PTS);
  localparam logic signed [CW-1:0] CMIN = -CMAX;
  localparam logic [IDX_W-1:0]     LAST = IDX_W'(N_PTS - 1);

  AST_COEF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid_o |-> (coef_val_o <= CMAX) && (coef_val_o >= CMIN)); // R3

  AST_COEF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid_o |-> (coef_val_o[0] == 1'b0)); // R3

  AST_ZERO_IS_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && coef_val_o == '0) |-> !coef_ess_o); // R4

  AST_FULL_IS_ESSENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && (coef_val_o == CMAX || coef_val_o == CMIN)) |-> coef_ess_o); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && $past(coef_valid_o)) |-> coef_idx_o == $past(coef_idx_o) + 1'b1); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(coef_valid_o) && ($past(coef_idx_o) == LAST)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !coef_valid_o); // R6

  AST_START_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid_o && start_i) |=> (coef_valid_o || done_o)); // R7

endmodule

bind walsh_spectrum_analyzer wsa_checker #(.N_PTS(N_PTS)) u_wsa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .coef_valid_o(coef_valid_o),
  .coef_idx_o  (coef_idx_o),
  .coef_val_o  (coef_val_o),
  .coef_ess_o  (coef_ess_o),
  .done_o      (done_o)
);

// File: tb/tb_walsh_spectrum_analyzer.sv
module tb_walsh_spectrum_analyzer;

  localparam int N  = 128;
  localparam int LG = 7;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic              bit_valid_i;
  logic              bit_i;
  logic              coef_valid_o;
  logic [LG-1:0]     coef_idx_o;
  logic signed [8:0] coef_val_o;
  logic              coef_ess_o;
  logic              done_o;

  int n_checks;
  int n_fails;

  walsh_spectrum_analyzer #(.N_PTS(N)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .coef_valid_o(coef_valid_o),
    .coef_idx_o  (coef_idx_o),
    .coef_val_o  (coef_val_o),
    .coef_ess_o  (coef_ess_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wcoef(input logic [N-1:0] p, input int k);
    int s;
    s = 0;
    for (int n = 0; n < N; n++) begin
      int v;
      v = p[n] ? 1 : -1;
      if (($countones(k & n) % 2) == 1) v = -v;
      s += v;
    end
    return s;
  endfunction

  task automatic run_case(input logic [N-1:0] pat, input bit gaps, input bit noise);
    int exp_c [N];
    int cyc, got, first;
    bit done_seen;
    for (int k = 0; k < N; k++) exp_c[k] = wcoef(pat, k);
    if (noise) begin
      // R7: bits offered before start must not be captured
      repeat (3) begin
        @(negedge clk);
        bit_valid_i = 1'b1;
        bit_i       = 1'($urandom);
      end
    end
    @(negedge clk);
    start_i     = 1'b1;
    bit_valid_i = 1'b0;
    for (int n = 0; n < N; n++) begin
      if (gaps) begin
        int g;
        g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          @(negedge clk);
          start_i     = 1'b0;
          bit_valid_i = 1'b0;
          bit_i       = 1'($urandom);
        end
      end
      @(negedge clk);
      start_i     = noise && (n == 50); // R7: restart attempt mid-capture
      bit_valid_i = 1'b1;
      bit_i       = pat[n];
    end
    cyc = 0; got = 0; first = -1; done_seen = 1'b0;
    while (!done_seen && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (coef_valid_o) begin
        if (first < 0) begin
          first = cyc;
          check(cyc == LG + 1, "R5", "first coefficient latency", cyc, LG + 1);
        end
        if (got < N) begin
          check(int'(coef_idx_o) == got, "R5", "coefficient index", int'(coef_idx_o), got);
          check(int'(coef_val_o) == exp_c[got], "R2", "coefficient value",
                int'(coef_val_o), exp_c[got]);
          check(coef_ess_o == (exp_c[got] * exp_c[got] > N), "R4", "essential flag",
                int'(coef_ess_o), int'(exp_c[got] * exp_c[got] > N));
        end
        got++;
      end
      if (done_o) begin
        done_seen = 1'b1;
        check(got == N, "R6", "coefficients before done", got, N);
        check(cyc == first + N, "R6", "done position", cyc, first + N);
      end
      if (noise) begin
        start_i     = 1'($urandom);
        bit_valid_i = 1'($urandom);
        bit_i       = 1'($urandom);
      end else begin
        start_i     = 1'b0;
        bit_valid_i = 1'b0;
      end
    end
    check(done_seen, "R6", "done pulse seen", int'(done_seen), 1);
    @(negedge clk);
    start_i     = 1'b0;
    bit_valid_i = 1'b0;
    check(!done_o && !coef_valid_o, "R6", "idle after done", int'(done_o | coef_valid_o), 0);
  endtask

  initial begin
    logic [N-1:0] pat;
    n_checks = 0;
    n_fails  = 0;
    void'($urandom(32'h5EED_1234));
    rst_n       = 1'b0;
    start_i     = 1'b0;
    bit_valid_i = 1'b0;
    bit_i       = 1'b0;
    repeat (3) @(negedge clk);
    check(!coef_valid_o && !done_o, "R8", "outputs in reset", int'(coef_valid_o | done_o), 0);
    check(coef_val_o == 0, "R8", "storage cleared in reset", int'(coef_val_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!coef_valid_o && coef_val_o == 0, "R8", "idle after reset release",
          int'(coef_val_o), 0);

    // R1/R2 directed: all ones, all zeros
    run_case({N{1'b1}}, 1'b0, 1'b0);
    run_case({N{1'b0}}, 1'b0, 1'b0);
    // R2: rows 1, 2 and N/2 of the Sylvester matrix
    for (int n = 0; n < N; n++) pat[n] = ~n[0];
    run_case(pat, 1'b0, 1'b0);
    for (int n = 0; n < N; n++) pat[n] = ~n[1];
    run_case(pat, 1'b1, 1'b0);
    for (int n = 0; n < N; n++) pat[n] = (n < N / 2);
    run_case(pat, 1'b0, 1'b0);
    // R4 boundary: coefficient 0 at +12 (essential) and +10 (noise)
    for (int n = 0; n < N; n++) pat[n] = (n < 70);
    run_case(pat, 1'b0, 1'b0);
    for (int n = 0; n < N; n++) pat[n] = (n < 69);
    run_case(pat, 1'b1, 1'b0);
    // random streams with gaps and ignored start / valid activity (R1, R7)
    for (int r = 0; r < 6; r++) begin
      for (int n = 0; n < N; n++) pat[n] = 1'($urandom);
      run_case(pat, 1'b1, r >= 2);
    end
    // sparse random streams: mostly one value, so the spectrum is small
    for (int r = 0; r < 2; r++) begin
      for (int n = 0; n < N; n++) pat[n] = ($urandom_range(0, 9) == 0);
      run_case(pat, 1'b1, 1'b1);
    end

    // R8: asynchronous reset during emission clears storage
    @(negedge clk);
    start_i = 1'b1;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      start_i     = 1'b0;
      bit_valid_i = 1'b1;
      bit_i       = 1'b1;
    end
    @(negedge clk);
    bit_valid_i = 1'b0;
    while (!coef_valid_o) @(negedge clk);
    check(int'(coef_val_o) == N, "R2", "all-ones coefficient before reset", int'(coef_val_o), N);
    #2 rst_n = 1'b0;
    #2;
    check(!coef_valid_o && !done_o, "R8", "async reset stops emission",
          int'(coef_valid_o | done_o), 0);
    check(coef_val_o == 0, "R8", "async reset clears storage", int'(coef_val_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(!coef_valid_o && coef_val_o == 0, "R8", "no resume after reset",
            int'(coef_val_o), 0);
    end
    for (int n = 0; n < N; n++) pat[n] = 1'($urandom);
    run_case(pat, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule